// File: doc/BRIEF.md
# Serial Transceiver with Parity Control

This block is an asynchronous serial transmitter and receiver for one full-duplex line pair. Software programs a 7-bit control word that holds the frame length, the parity mode, three interrupt enables and a stored wake-up method field. It then writes bytes (or 9-bit words) into a transmit holding register and reads received words from a data output. Every line bit lasts a fixed number of clocks. A free-running tick divider makes a 16x oversampling tick, and the receiver samples each bit near its centre.

When parity is on, the transmitter computes the parity of the payload. It writes that parity bit into the top bit position of the word instead of the data bit that would sit there, so the frame length stays the same. The receiver checks the same position and raises a sticky error flag on a mismatch. Each direction takes its frame length and parity settings when a frame starts, so a mid-frame change to the control word only affects later frames. One registered interrupt line combines the enabled status conditions.

Top module: `sio_parity_core`

## Requirements
- R1: After reset the control word reads 0, `tdr_empty` and `tx_done` are 1, `par_err`, `irq` and `rx_valid` are 0, and `txd` idles high.
- R2: A transmitted frame is one low start bit, then the data bits least significant first, then one high stop bit. Each bit lasts 64 clocks with the default parameters. Control bit 0 (`word9`) selects 9 data bits when 1 and 8 data bits when 0.
- R3: With control bit 1 (`par_en`) set, the transmitter replaces the top data bit with parity. In 9-bit mode that is bit 8, in 8-bit mode bit 7. The parity is computed over the lower bits, and control bit 2 (`par_odd`) picks even (0) or odd (1). In 8-bit mode, `tx_data[8]` is ignored.
- R4: With parity enabled, a received frame whose bits (parity bit included) fail the selected parity sets `par_err`. The flag stays set until an `err_clr` pulse. With parity disabled, no frame sets it.
- R5: Frame length and parity settings are captured when a frame starts, in each direction. Changing them during a frame has no effect on that frame.
- R6: A `tx_wr` pulse clears `tdr_empty` and `tx_done`. `tdr_empty` sets again when the word moves into the shifter. `tx_done` sets when a stop bit ends and no word is waiting.
- R7: `irq` is registered one cycle after the OR of three terms: `tdr_empty` AND control bit 4, `tx_done` AND control bit 5, and `par_err` AND control bit 6.
- R8: When a received frame's stop bit is sampled, `rx_valid` pulses for one cycle and `rx_data` holds the received bits. The parity bit is included as received, and bit 8 is 0 in 8-bit mode.
- R9: Control bit 3 (`wake_addr`, 0 = idle line, 1 = address mark) is stored and read back on `ctrl_q` but does not change the frame. `ctrl_q` changes only on a `cfg_wr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Control word: b0 word9, b1 par_en, b2 par_odd, b3 wake_addr, b4 txe irq en, b5 tc irq en, b6 perr irq en |
| ctrl_q | output | 7 | Control word readback |
| tx_wr | input | 1 | Transmit holding register write strobe |
| tx_data | input | 9 | Word to transmit |
| tdr_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Transmission complete |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |
| rx_data | output | 9 | Last received word |
| rx_valid | output | 1 | One-cycle pulse per received frame |
| par_err | output | 1 | Sticky parity error flag |
| err_clr | input | 1 | Clears the parity error flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Several internal faults show up as a wrong bit on `txd` within one bit time of where it happens. These include a wrong latched parity mode, a wrong bit counter or the wrong parity polarity, and the bench reads the line back at mid-bit. A receiver that samples at the wrong point or checks the wrong bit count gives a wrong `rx_data` word, or a false or missing `par_err`, at the first stop bit after the fault. Flag sequencing faults in the holding register show on `tdr_empty`, `tx_done` and `irq` within one or two clocks of the write, the load or the stop bit. Control words rewritten mid-frame expose any setting that was not latched at frame start.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned DATA_W = 9;

  typedef struct packed {
    logic ie_perr;
    logic ie_tc;
    logic ie_txe;
    logic wake_addr;
    logic par_odd;
    logic par_en;
    logic word9;
  } sio_ctrl_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  // Mask of the bits a frame carries; drop_msb removes the parity slot.
  function automatic logic [DATA_W-1:0] lane_mask(input logic word9, input logic drop_msb);
    logic [DATA_W-1:0] m;
    m = word9 ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
    if (drop_msb) m = m >> 1;
    return m;
  endfunction

  function automatic logic parity_of(input logic [DATA_W-1:0] bits,
                                     input logic [DATA_W-1:0] mask, input logic odd);
    return (^(bits & mask)) ^ odd;
  endfunction

  // Word placed on the line, with parity in the top slot when enabled.
  function automatic logic [DATA_W-1:0] tx_line_word(input logic [DATA_W-1:0] data,
      input logic word9, input logic par_en, input logic odd);
    logic [DATA_W-1:0] w;
    logic p;
    w = data & lane_mask(word9, 1'b0);
    p = parity_of(data, lane_mask(word9, 1'b1), odd);
    if (par_en) begin
      if (word9) w[DATA_W-1] = p;
      else       w[DATA_W-2] = p;
    end
    return w;
  endfunction

  function automatic logic rx_parity_bad(input logic [DATA_W-1:0] bits,
                                         input logic word9, input logic odd);
    return (^(bits & lane_mask(word9, 1'b0))) != odd;
  endfunction
endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen #(
  parameter int unsigned CLK_PER_TICK = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == CW'(CLK_PER_TICK - 1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx import sio_pkg::*; #(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              word9,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              txd,
  output logic              tdr_empty,
  output logic              tx_done,
  output logic              tx_busy
);
  localparam int unsigned SW = $clog2(OVS);
  localparam int unsigned FW = DATA_W + 2;
  localparam int unsigned LW = $clog2(FW + 1);

  logic [DATA_W-1:0] tdr_q;
  logic              tdr_full_q, done_q, busy_q;
  logic [FW-1:0]     frame_q;
  logic [LW-1:0]     left_q;
  logic [SW-1:0]     sub_q;
  logic [DATA_W-1:0] word_w;
  logic              load_evt, bit_end, end_evt;

  assign word_w   = tx_line_word(tdr_q, word9, par_en, par_odd);
  assign load_evt = !busy_q && tdr_full_q;
  assign bit_end  = busy_q && tick && (sub_q == SW'(OVS - 1));
  assign end_evt  = bit_end && (left_q == LW'(1));

  // Settings are sampled only at load_evt, so they hold for the whole frame.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      left_q  <= '0;
      sub_q   <= '0;
    end else if (load_evt) begin
      busy_q  <= 1'b1;
      sub_q   <= '0;
      left_q  <= word9 ? LW'(FW) : LW'(FW - 1);
      frame_q <= word9 ? {1'b1, word_w, 1'b0}
                       : {2'b11, word_w[DATA_W-2:0], 1'b0};
    end else if (busy_q && tick) begin
      if (bit_end) begin
        sub_q   <= '0;
        frame_q <= {1'b1, frame_q[FW-1:1]};
        left_q  <= left_q - 1'b1;
        if (end_evt) busy_q <= 1'b0;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdr_q      <= '0;
      tdr_full_q <= 1'b0;
      done_q     <= 1'b1;
    end else begin
      if (tx_wr) tdr_q <= tx_data;
      if (tx_wr)         tdr_full_q <= 1'b1;
      else if (load_evt) tdr_full_q <= 1'b0;
      if (tx_wr)                         done_q <= 1'b0;
      else if (end_evt && !tdr_full_q)   done_q <= 1'b1;
    end
  end

  assign txd       = busy_q ? frame_q[0] : 1'b1;
  assign tdr_empty = !tdr_full_q;
  assign tx_done   = done_q;
  assign tx_busy   = busy_q;
endmodule

// File: rtl/sio_rx.sv
module sio_rx import sio_pkg::*; #(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              word9,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              rx_par_en
);
  localparam int unsigned SW = $clog2(OVS);
  localparam int unsigned IW = $clog2(DATA_W + 1);

  logic [1:0]        sync_q;
  logic              rxd_s;
  rx_state_t         st_q;
  logic [SW-1:0]     sub_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sh_q, data_q, assembled;
  logic              w9_q, pe_q, odd_q, valid_q, err_q;
  logic              mid_end, stop_hit, perr_set;

  assign rxd_s     = sync_q[1];
  assign mid_end   = tick && (sub_q == SW'(OVS - 1));
  assign stop_hit  = (st_q == RX_STOP) && mid_end;
  assign assembled = w9_q ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
  assign perr_set  = stop_hit && pe_q && rx_parity_bad(assembled, w9_q, odd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      w9_q    <= 1'b0;
      pe_q    <= 1'b0;
      odd_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (!rxd_s) begin
          st_q  <= RX_START;
          sub_q <= '0;
          w9_q  <= word9;
          pe_q  <= par_en;
          odd_q <= par_odd;
        end
        RX_START: if (tick) begin
          if (sub_q == SW'(OVS/2 - 1)) begin
            sub_q <= '0;
            idx_q <= '0;
            st_q  <= rxd_s ? RX_IDLE : RX_DATA;
          end else sub_q <= sub_q + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (mid_end) begin
            sub_q <= '0;
            sh_q  <= {rxd_s, sh_q[DATA_W-1:1]};
            if (idx_q == (w9_q ? IW'(DATA_W - 1) : IW'(DATA_W - 2))) st_q <= RX_STOP;
            else idx_q <= idx_q + 1'b1;
          end else sub_q <= sub_q + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (mid_end) begin
            sub_q   <= '0;
            valid_q <= 1'b1;
            data_q  <= assembled;
            st_q    <= RX_IDLE;
          end else sub_q <= sub_q + 1'b1;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (perr_set) err_q <= 1'b1;
    else if (err_clr)  err_q <= 1'b0;
  end

  assign rx_data   = data_q;
  assign rx_valid  = valid_q;
  assign par_err   = err_q;
  assign rx_par_en = pe_q;
endmodule

// File: rtl/sio_irq.sv
module sio_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tdr_empty,
  input  logic tx_done,
  input  logic par_err,
  input  logic en_txe,
  input  logic en_tc,
  input  logic en_pe,
  output logic irq
);
  logic any_src;
  assign any_src = (tdr_empty & en_txe) | (tx_done & en_tc) | (par_err & en_pe);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_src;
  end
endmodule

// File: rtl/sio_parity_core.sv
module sio_parity_core import sio_pkg::*; #(
  parameter int unsigned CLK_PER_TICK = 4,
  parameter int unsigned OVS          = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [6:0]        cfg_wdata,
  output logic [6:0]        ctrl_q,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tdr_empty,
  output logic              tx_done,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  input  logic              err_clr,
  output logic              irq
);
  sio_ctrl_t ctrl_r;
  logic      tick_w, tx_busy_w, rx_par_en_w;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_r <= '0;
    else if (cfg_wr) ctrl_r <= sio_ctrl_t'(cfg_wdata);
  end
  assign ctrl_q = ctrl_r;

  sio_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  sio_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick_w),
    .tx_wr(tx_wr), .tx_data(tx_data),
    .word9(ctrl_r.word9), .par_en(ctrl_r.par_en), .par_odd(ctrl_r.par_odd),
    .txd(txd), .tdr_empty(tdr_empty), .tx_done(tx_done), .tx_busy(tx_busy_w)
  );

  sio_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .rxd(rxd),
    .word9(ctrl_r.word9), .par_en(ctrl_r.par_en), .par_odd(ctrl_r.par_odd),
    .err_clr(err_clr), .rx_data(rx_data), .rx_valid(rx_valid),
    .par_err(par_err), .rx_par_en(rx_par_en_w)
  );

  sio_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .tdr_empty(tdr_empty), .tx_done(tx_done), .par_err(par_err),
    .en_txe(ctrl_r.ie_txe), .en_tc(ctrl_r.ie_tc), .en_pe(ctrl_r.ie_perr),
    .irq(irq)
  );
endmodule

// File: rtl/sio_checker.sv
module sio_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [6:0] ctrl_q,
  input logic       tx_wr,
  input logic       tdr_empty,
  input logic       tx_done,
  input logic       txd,
  input logic       tx_busy,
  input logic       par_err,
  input logic       err_clr,
  input logic       rx_par_en,
  input logic       rx_valid,
  input logic       irq
);
  logic src;
  assign src = (tdr_empty & ctrl_q[4]) | (tx_done & ctrl_q[5]) | (par_err & ctrl_q[6]);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  assert_perr_needs_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> $past(rx_par_en));
  assert_perr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err);
  assert_wr_clears_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tdr_empty);
  assert_wr_clears_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_done);
  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    src |=> irq);
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(src));
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(ctrl_q));
endmodule

bind sio_parity_core sio_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .ctrl_q(ctrl_q),
  .tx_wr(tx_wr), .tdr_empty(tdr_empty), .tx_done(tx_done), .txd(txd),
  .tx_busy(tx_busy_w), .par_err(par_err), .err_clr(err_clr),
  .rx_par_en(rx_par_en_w), .rx_valid(rx_valid), .irq(irq)
);

// File: tb/tb_sio_parity_core.sv
module tb_sio_parity_core;
  localparam int CPT  = 4;
  localparam int OVS  = 16;
  localparam int BITC = CPT * OVS;
  localparam int NV   = 8;
  // {ctrl[6:0], tx_data[8:0], expected line/rx word[8:0]}
  localparam logic [24:0] VEC [NV] = '{
    {7'h00, 9'h0A5, 9'h0A5},   // 8-bit, no parity
    {7'h02, 9'h013, 9'h093},   // 8-bit even: bit7 <- 1
    {7'h06, 9'h013, 9'h013},   // 8-bit odd: bit7 <- 0
    {7'h01, 9'h1C3, 9'h1C3},   // 9-bit, no parity
    {7'h03, 9'h1FF, 9'h0FF},   // 9-bit even: bit8 <- 0
    {7'h07, 9'h0FF, 9'h1FF},   // 9-bit odd: bit8 <- 1
    {7'h02, 9'h180, 9'h000},   // 8-bit even, tx_data[8] ignored
    {7'h08, 9'h03C, 9'h03C}    // wake field set, frame unchanged
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, cfg_wr = 1'b0, tx_wr = 1'b0, err_clr = 1'b0;
  logic       loop_en = 1'b0, brx = 1'b1;
  logic [6:0] cfg_wdata = '0;
  logic [8:0] tx_data = '0;
  wire  [6:0] ctrl_q;
  wire  [8:0] rx_data;
  wire        tdr_empty, tx_done, txd, rx_valid, par_err, irq;
  wire        rxd = loop_en ? txd : brx;

  int checks = 0, errors = 0, rx_seen = 0, rx_exp = 0;
  bit finished = 1'b0;
  logic [8:0] cap_bits;
  logic       cap_start, cap_stop;

  sio_parity_core dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q),
    .tx_wr(tx_wr), .tx_data(tx_data), .tdr_empty(tdr_empty), .tx_done(tx_done),
    .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .par_err(par_err), .err_clr(err_clr), .irq(irq)
  );

  always @(negedge clk) if (rx_valid) rx_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [6:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; wait_n(1); cfg_wr = 1'b0;
  endtask

  task automatic wr_tx(input logic [8:0] v);
    tx_wr = 1'b1; tx_data = v; wait_n(1); tx_wr = 1'b0;
  endtask

  task automatic send(input int n, input logic [8:0] bits);
    brx = 1'b0; wait_n(BITC);
    for (int i = 0; i < n; i++) begin brx = bits[i]; wait_n(BITC); end
    brx = 1'b1; wait_n(BITC);
  endtask

  task automatic cap(input int n);
    while (txd !== 1'b0) @(negedge clk);
    wait_n(BITC / 2);
    cap_start = txd;
    cap_bits  = '0;
    for (int i = 0; i < n; i++) begin wait_n(BITC); cap_bits[i] = txd; end
    wait_n(BITC);
    cap_stop = txd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(3);
    chk("R1 ctrl", ctrl_q, 7'h00);
    chk("R1 tdr_empty", tdr_empty, 1);
    chk("R1 tx_done", tx_done, 1);
    chk("R1 par_err", par_err, 0);
    chk("R1 irq", irq, 0);
    chk("R1 txd", txd, 1);

    // R9 stored wake field and R7 enables
    wr_ctrl(7'h08); chk("R9 readback", ctrl_q, 7'h08);
    wr_ctrl(7'h10); wait_n(2); chk("R7 txe irq", irq, 1);
    wr_ctrl(7'h20); wait_n(2); chk("R7 tc irq", irq, 1);
    wr_ctrl(7'h40); wait_n(2); chk("R7 perr irq off", irq, 0);
    wr_ctrl(7'h00); wait_n(2); chk("R7 none", irq, 0);

    // R2 R3 R8 vector walk in loopback
    loop_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      wr_ctrl(VEC[v][24:18]);
      fork
        cap(VEC[v][18] ? 9 : 8);
        wr_tx(VEC[v][17:9]);
      join
      rx_exp++;
      chk($sformatf("R2 framing v%0d", v), {cap_start, cap_stop}, 2'b01);
      chk($sformatf("R3 line word v%0d", v), cap_bits, VEC[v][8:0]);
      wait_n(BITC);
      chk($sformatf("R8 rx_data v%0d", v), rx_data, VEC[v][8:0]);
      chk($sformatf("R4 no false error v%0d", v), par_err, 0);
      chk($sformatf("R6 tx_done v%0d", v), tx_done, 1);
    end
    chk("R8 rx count", rx_seen, rx_exp);
    chk("R9 wake kept", ctrl_q, 7'h08);

    // R5 transmit: parity turned off mid-frame keeps this frame's parity
    wr_ctrl(7'h02);
    fork
      cap(8);
      begin wr_tx(9'h013); wait_n(3 * BITC); wr_ctrl(7'h00); end
    join
    wait_n(BITC);
    chk("R5 tx latched parity", cap_bits, 9'h093);
    chk("R5 rx latched parity", rx_data, 9'h093);
    fork cap(8); wr_tx(9'h013); join
    wait_n(BITC);
    chk("R5 next frame plain", cap_bits, 9'h013);
    loop_en = 1'b0;

    // R6 holding register sequencing
    wr_tx(9'h055);
    chk("R6 empty cleared", tdr_empty, 0);
    chk("R6 done cleared", tx_done, 0);
    wait_n(2);
    chk("R6 empty after load", tdr_empty, 1);
    wr_tx(9'h0AA);
    wait_n(5 * BITC);
    chk("R6 second pending", tdr_empty, 0);
    wait_n(7 * BITC);
    chk("R6 second loaded", tdr_empty, 1);
    chk("R6 done held", tx_done, 0);
    wait_n(10 * BITC);
    chk("R6 done after last", tx_done, 1);

    // R4 receive parity check
    wr_ctrl(7'h02);
    send(8, 9'h081);
    chk("R4 good even frame", par_err, 0);
    wr_ctrl(7'h42);
    send(8, 9'h001);
    chk("R4 bad even frame", par_err, 1);
    chk("R8 rx data bad frame", rx_data, 9'h001);
    wait_n(2);
    chk("R7 perr irq", irq, 1);
    send(8, 9'h081);
    chk("R4 sticky", par_err, 1);
    err_clr = 1'b1; wait_n(1); err_clr = 1'b0; wait_n(2);
    chk("R4 cleared", par_err, 0);
    chk("R7 irq dropped", irq, 0);
    wr_ctrl(7'h07);
    send(9, 9'h003);
    chk("R4 bad odd 9-bit", par_err, 1);
    chk("R8 rx 9-bit", rx_data, 9'h003);
    err_clr = 1'b1; wait_n(1); err_clr = 1'b0;
    wr_ctrl(7'h00);
    send(8, 9'h001);
    chk("R4 parity off ignores", par_err, 0);

    // R5 receive: parity disabled mid-frame still checks this frame
    wr_ctrl(7'h02);
    fork
      send(8, 9'h001);
      begin wait_n(3 * BITC); wr_ctrl(7'h00); end
    join
    chk("R5 rx check latched", par_err, 1);
    err_clr = 1'b1; wait_n(1); err_clr = 1'b0;
    send(8, 9'h001);
    chk("R5 later frame unchecked", par_err, 0);

    wr_ctrl(7'h7F);
    chk("R9 full write", ctrl_q, 7'h7F);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule